// File: doc/BRIEF.md
# MDIO Management Register Slave

This block is a serial management slave. A management master reaches it over a two-wire clocked data line, using Clause 22 style frames. Through it the master reads four 32-bit status words and writes two 32-bit configuration words. Management frames carry only 16 data bits, so each 32-bit word is split into a low half and a high half, and each half has its own register address.

The slave answers only when the port address in a frame equals the value on its port-address input, which is normally tied to 0x15. The management clock and data inputs are oversampled in the local clock domain. The slave drives its data output together with an output-enable, so an external bidirectional pad can be built from them.

Each configuration half has its own valid pulse, which marks the cycle in which that half takes a new value. Reading the low half of a status word captures the upper half of the same word. A later read of the high half returns that captured value, so the two halves of a 32-bit status value come from one instant.

Top module: `mdio_cfg_slave`

## Requirements
- R1: After reset, mdo_en is 0, both configuration words are 0 and all four valid outputs are 0.
- R2: A frame is decoded only after at least 32 consecutive 1 bits, sampled on mdc rising edges. It then needs start bits 0,1, a 2-bit opcode (01 write, 10 read), a 5-bit port address, a 5-bit register address, 2 turnaround bits and 16 data bits, all MSB first. If fewer than 32 ones come before the start bits, the whole frame is ignored.
- R3: A frame whose port address differs from port_addr neither writes a register nor raises mdo_en.
- R4: Register addresses 0 to 7 read the status words. Address 2k returns status k bits 15:0, for k = 0..3.
- R5: Address 2k+1 returns the upper 16 bits of status k as they stood at the most recent read of address 2k. Before any such read it returns 0.
- R6: A write updates only the addressed half. Address 8 is cfg0[15:0], address 9 is cfg0[31:16], address 10 is cfg1[15:0] and address 11 is cfg1[31:16]. The other half and the other word keep their values.
- R7: Each configuration write raises only the valid output of the half it wrote (cfg0_lo_vld, cfg0_hi_vld, cfg1_lo_vld or cfg1_hi_vld). The pulse lasts exactly one clk cycle, and in that cycle the configuration output already shows the new value.
- R8: Reads of addresses 8 to 11 return the stored configuration halves. Reads of addresses 12 to 31 return 0.
- R9: During a matching read, mdo_en stays 0 through the address bits. It goes to 1 after the mdc edge that samples the first turnaround bit, with mdo = 0. mdo then presents the 16 data bits MSB first, each changing after an mdc rising edge. mdo_en returns to 0 after the edge that samples the last data bit.
- R10: Writes to addresses 0 to 7 or 12 to 31 change nothing and raise no valid output. Frames with opcode 00 or 11 neither write nor raise mdo_en.
- R11: The port address to match is taken from port_addr when a frame is decoded, so changing that input changes which frames are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock used to oversample the management signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the master |
| mdi | input | 1 | Management data into the slave |
| port_addr | input | 5 | Port address the slave answers to (normally 0x15) |
| status0 | input | 32 | Read-only status word 0 |
| status1 | input | 32 | Read-only status word 1 |
| status2 | input | 32 | Read-only status word 2 |
| status3 | input | 32 | Read-only status word 3 |
| mdo | output | 1 | Management data driven by the slave |
| mdo_en | output | 1 | Output-enable for mdo |
| cfg0 | output | 32 | Configuration word 0 |
| cfg1 | output | 32 | Configuration word 1 |
| cfg0_lo_vld | output | 1 | One-cycle pulse when cfg0[15:0] is written |
| cfg0_hi_vld | output | 1 | One-cycle pulse when cfg0[31:16] is written |
| cfg1_lo_vld | output | 1 | One-cycle pulse when cfg1[15:0] is written |
| cfg1_hi_vld | output | 1 | One-cycle pulse when cfg1[31:16] is written |

## Verification
A fault in the frame state machine or in its bit counter shows up in the very frame that follows. The turnaround bit comes one mdc period early or late, mdo_en is counted high for a number of bit periods other than 17, or the read data is shifted by one bit. A wrong half-select or a stray write in the register store shows at the configuration outputs and valid pulses within a few clk cycles of the last data bit, and again on the next readback. A stale or missing capture of the upper status half appears only on the next read of an odd address, so the bench always pairs low and high reads and changes the status inputs between them.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        FS_PRE   = 3'd0,
        FS_START = 3'd1,
        FS_OP    = 3'd2,
        FS_ADDR  = 3'd3,
        FS_TA    = 3'd4,
        FS_DATA  = 3'd5
    } fsm_e;

    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;

    localparam int PORT_AW = 5;
    localparam int REG_AW  = 5;
    localparam int HALF_W  = 16;

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_in,
    input  logic mdi_in,
    output logic mdc_rise,
    output logic bit_val
);

    logic [STAGES-1:0] mdc_d, mdc_q;
    logic [STAGES-1:0] mdi_d, mdi_q;
    logic              last_d, last_q;

    always_comb begin
        mdc_d  = {mdc_q[STAGES-2:0], mdc_in};
        mdi_d  = {mdi_q[STAGES-2:0], mdi_in};
        last_d = mdc_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_q  <= '0;
            mdi_q  <= '0;
            last_q <= 1'b0;
        end else begin
            mdc_q  <= mdc_d;
            mdi_q  <= mdi_d;
            last_q <= last_d;
        end
    end

    assign mdc_rise = mdc_q[STAGES-1] & ~last_q;
    assign bit_val  = mdi_q[STAGES-1];

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_vld,
    input  logic                bit_val,
    input  logic [PORT_AW-1:0]  port_addr,
    input  logic [HALF_W-1:0]   rd_data,
    output logic                mdo,
    output logic                mdo_en,
    output logic                rd_req,
    output logic                wr_stb,
    output logic [REG_AW-1:0]   reg_addr,
    output logic [HALF_W-1:0]   wr_data
);

    localparam int CW_PRE = $clog2(PRE_LEN + 1);
    localparam int CW     = (CW_PRE > 4) ? CW_PRE : 4;
    localparam int AF_W   = PORT_AW + REG_AW;
    localparam logic [CW-1:0] PRE_MAX   = CW'(PRE_LEN);
    localparam logic [CW-1:0] OP_LAST   = CW'(1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(AF_W - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(HALF_W - 1);

    typedef struct packed {
        fsm_e              st;
        logic [CW-1:0]     cnt;
        logic [1:0]        op;
        logic [AF_W-1:0]   ash;
        logic              hit;
        logic [REG_AW-1:0] regad;
        logic [HALF_W-1:0] wsh;
        logic [HALF_W-1:0] rsh;
        logic              mdo;
        logic              oe;
        logic              rd_req;
        logic              wr_stb;
    } frm_t;

    frm_t            d, q;
    logic [AF_W-1:0] addr_full;
    logic            is_rd;

    always_comb begin
        d         = q;
        d.rd_req  = 1'b0;
        d.wr_stb  = 1'b0;
        addr_full = {q.ash[AF_W-2:0], bit_val};
        is_rd     = q.hit && (q.op == OP_RD);

        if (q.rd_req) begin
            d.rsh = rd_data;
        end

        if (bit_vld) begin
            unique case (q.st)
                FS_PRE: begin
                    if (bit_val) begin
                        if (q.cnt != PRE_MAX) d.cnt = q.cnt + 1'b1;
                    end else if (q.cnt == PRE_MAX) begin
                        d.st  = FS_START;
                        d.cnt = '0;
                    end else begin
                        d.cnt = '0;
                    end
                end
                FS_START: begin
                    d.cnt = '0;
                    d.st  = bit_val ? FS_OP : FS_PRE;
                end
                FS_OP: begin
                    d.op = {q.op[0], bit_val};
                    if (q.cnt == OP_LAST) begin
                        d.st  = FS_ADDR;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                FS_ADDR: begin
                    d.ash = addr_full;
                    if (q.cnt == ADDR_LAST) begin
                        d.regad  = addr_full[REG_AW-1:0];
                        d.hit    = (addr_full[AF_W-1:REG_AW] == port_addr) &&
                                   ((q.op == OP_WR) || (q.op == OP_RD));
                        d.rd_req = (addr_full[AF_W-1:REG_AW] == port_addr) &&
                                   (q.op == OP_RD);
                        d.st     = FS_TA;
                        d.cnt    = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                FS_TA: begin
                    if (q.cnt == '0) begin
                        d.cnt = q.cnt + 1'b1;
                        if (is_rd) begin
                            d.oe  = 1'b1;
                            d.mdo = 1'b0;
                        end
                    end else begin
                        d.st  = FS_DATA;
                        d.cnt = '0;
                        if (is_rd) begin
                            d.mdo = q.rsh[HALF_W-1];
                            d.rsh = {q.rsh[HALF_W-2:0], 1'b0};
                        end
                    end
                end
                FS_DATA: begin
                    d.wsh = {q.wsh[HALF_W-2:0], bit_val};
                    if (q.cnt == DATA_LAST) begin
                        d.oe     = 1'b0;
                        d.mdo    = 1'b0;
                        d.wr_stb = q.hit && (q.op == OP_WR);
                        d.st     = FS_PRE;
                        d.cnt    = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                        if (is_rd) begin
                            d.mdo = q.rsh[HALF_W-1];
                            d.rsh = {q.rsh[HALF_W-2:0], 1'b0};
                        end
                    end
                end
                default: begin
                    d.st  = FS_PRE;
                    d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: FS_PRE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mdo      = q.mdo;
    assign mdo_en   = q.oe;
    assign rd_req   = q.rd_req;
    assign wr_stb   = q.wr_stb;
    assign reg_addr = q.regad;
    assign wr_data  = q.wsh;

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.hit && (q.op == OP_RD))); // R9
    AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> ((q.st == FS_TA) || (q.st == FS_DATA))); // R9
    AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !q.mdo); // R9
    AST_WRITE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_stb |-> (q.hit && (q.op == OP_WR))); // R3
    AST_RDREQ_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_req |-> !q.oe); // R9

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
#(
    parameter int NSTAT = 4,
    parameter int NCFG  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NSTAT-1:0][2*HALF_W-1:0]    stat_i,
    input  logic                              rd_req,
    input  logic                              wr_stb,
    input  logic [REG_AW-1:0]                 reg_addr,
    input  logic [HALF_W-1:0]                 wr_data,
    output logic [HALF_W-1:0]                 rd_data,
    output logic [NCFG-1:0][2*HALF_W-1:0]     cfg_o,
    output logic [2*NCFG-1:0]                 vld_o
);

    localparam int HW       = HALF_W;
    localparam int DW       = 2 * HALF_W;
    localparam int CFG_BASE = 2 * NSTAT;
    localparam int NHALF    = 2 * NCFG;

    typedef struct packed {
        logic [NSTAT-1:0][HW-1:0] hold;
        logic [NCFG-1:0][DW-1:0]  cfg;
        logic [NHALF-1:0]         vld;
    } rf_t;

    rf_t d, q;

    always_comb begin
        d     = q;
        d.vld = '0;
        for (int i = 0; i < NSTAT; i++) begin
            if (rd_req && (reg_addr == REG_AW'(2 * i))) begin
                d.hold[i] = stat_i[i][DW-1:HW];
            end
        end
        for (int j = 0; j < NHALF; j++) begin
            if (wr_stb && (reg_addr == REG_AW'(CFG_BASE + j))) begin
                d.vld[j]                       = 1'b1;
                d.cfg[j/2][(j%2)*HW +: HW]     = wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NSTAT; i++) begin
            if (reg_addr == REG_AW'(2 * i))     rd_data = stat_i[i][HW-1:0];
            if (reg_addr == REG_AW'(2 * i + 1)) rd_data = q.hold[i];
        end
        for (int j = 0; j < NHALF; j++) begin
            if (reg_addr == REG_AW'(CFG_BASE + j)) rd_data = q.cfg[j/2][(j%2)*HW +: HW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cfg_o = q.cfg;
    assign vld_o = q.vld;

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.vld)); // R7
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|q.vld) |=> !(|q.vld)); // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(q.cfg)); // R6
    AST_CAPTURE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(q.hold)); // R5

endmodule

// File: rtl/mdio_cfg_slave.sv
module mdio_cfg_slave
    import mdio_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_LEN     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mdc,
    input  logic        mdi,
    input  logic [4:0]  port_addr,
    input  logic [31:0] status0,
    input  logic [31:0] status1,
    input  logic [31:0] status2,
    input  logic [31:0] status3,
    output logic        mdo,
    output logic        mdo_en,
    output logic [31:0] cfg0,
    output logic [31:0] cfg1,
    output logic        cfg0_lo_vld,
    output logic        cfg0_hi_vld,
    output logic        cfg1_lo_vld,
    output logic        cfg1_hi_vld
);

    localparam int NSTAT = 4;
    localparam int NCFG  = 2;

    logic                          mdc_rise;
    logic                          bit_val;
    logic                          rd_req;
    logic                          wr_stb;
    logic [REG_AW-1:0]             reg_addr;
    logic [HALF_W-1:0]             wr_data;
    logic [HALF_W-1:0]             rd_data;
    logic [NSTAT-1:0][2*HALF_W-1:0] stat_w;
    logic [NCFG-1:0][2*HALF_W-1:0]  cfg_w;
    logic [2*NCFG-1:0]             vld_w;

    assign stat_w = {status3, status2, status1, status0};

    mdio_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc_in   (mdc),
        .mdi_in   (mdi),
        .mdc_rise (mdc_rise),
        .bit_val  (bit_val)
    );

    mdio_frame #(
        .PRE_LEN (PRE_LEN)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (mdc_rise),
        .bit_val   (bit_val),
        .port_addr (port_addr),
        .rd_data   (rd_data),
        .mdo       (mdo),
        .mdo_en    (mdo_en),
        .rd_req    (rd_req),
        .wr_stb    (wr_stb),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data)
    );

    mdio_regfile #(
        .NSTAT (NSTAT),
        .NCFG  (NCFG)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_i   (stat_w),
        .rd_req   (rd_req),
        .wr_stb   (wr_stb),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .cfg_o    (cfg_w),
        .vld_o    (vld_w)
    );

    assign cfg0        = cfg_w[0];
    assign cfg1        = cfg_w[1];
    assign cfg0_lo_vld = vld_w[0];
    assign cfg0_hi_vld = vld_w[1];
    assign cfg1_lo_vld = vld_w[2];
    assign cfg1_hi_vld = vld_w[3];

endmodule

// File: tb/mdio_cfg_slave_tb.sv
module mdio_cfg_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mdc;
    logic        mdi;
    logic [4:0]  port_addr;
    logic [31:0] status0, status1, status2, status3;
    logic        mdo, mdo_en;
    logic [31:0] cfg0, cfg1;
    logic        cfg0_lo_vld, cfg0_hi_vld, cfg1_lo_vld, cfg1_hi_vld;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int          vld_cnt [4];
    logic [31:0] vld_val [4];
    int          wide = 0;
    logic [3:0]  vld_prev = 4'b0;

    always #2 clk = ~clk;

    mdio_cfg_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mdc         (mdc),
        .mdi         (mdi),
        .port_addr   (port_addr),
        .status0     (status0),
        .status1     (status1),
        .status2     (status2),
        .status3     (status3),
        .mdo         (mdo),
        .mdo_en      (mdo_en),
        .cfg0        (cfg0),
        .cfg1        (cfg1),
        .cfg0_lo_vld (cfg0_lo_vld),
        .cfg0_hi_vld (cfg0_hi_vld),
        .cfg1_lo_vld (cfg1_lo_vld),
        .cfg1_hi_vld (cfg1_hi_vld)
    );

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        logic [3:0] vec;
        vec = {cfg1_hi_vld, cfg1_lo_vld, cfg0_hi_vld, cfg0_lo_vld};
        for (int k = 0; k < 4; k++) begin
            if (vec[k]) begin
                vld_cnt[k] = vld_cnt[k] + 1;
                vld_val[k] = (k < 2) ? cfg0 : cfg1;
                if (vld_prev[k]) wide = wide + 1;
            end
        end
        vld_prev = vec;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic mbit(input logic b, output logic s_mdo, output logic s_oe);
        mdi = b;
        repeat (8) @(posedge clk);
        #1;
        s_mdo = mdo;
        s_oe  = mdo_en;
        mdc   = 1'b1;
        repeat (8) @(posedge clk);
        #1;
        mdc   = 1'b0;
    endtask

    task automatic run_frame(input int pre, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] wd, output logic [15:0] rd,
                             output int oe_n, output logic ta_oe,
                             output logic ta_mdo, output logic end_oe);
        logic        s_m, s_o;
        logic [13:0] hdr;
        oe_n = 0;
        rd   = '0;
        mbit(1'b0, s_m, s_o);
        if (s_o) oe_n++;
        for (int i = 0; i < pre; i++) begin
            mbit(1'b1, s_m, s_o);
            if (s_o) oe_n++;
        end
        hdr = {2'b01, op, phy, ra};
        for (int i = 13; i >= 0; i--) begin
            mbit(hdr[i], s_m, s_o);
            if (s_o) oe_n++;
        end
        mbit(1'b1, s_m, s_o);
        if (s_o) oe_n++;
        mbit((op == 2'b01) ? 1'b0 : 1'b1, s_m, s_o);
        ta_oe  = s_o;
        ta_mdo = s_m;
        if (s_o) oe_n++;
        for (int i = 15; i >= 0; i--) begin
            mbit((op == 2'b01) ? wd[i] : 1'b1, s_m, s_o);
            rd[i] = s_m;
            if (s_o) oe_n++;
        end
        mbit(1'b1, s_m, s_o);
        end_oe = s_o;
        if (s_o) oe_n++;
    endtask

    task automatic rd_reg(input logic [4:0] phy, input logic [4:0] ra,
                          output logic [15:0] v, output logic ok);
        int   n;
        logic t_o, t_m, e_o;
        run_frame(32, 2'b10, phy, ra, 16'h0, v, n, t_o, t_m, e_o);
        ok = (n == 17) && t_o && !t_m && !e_o;
    endtask

    task automatic wr_reg(input int pre, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] wd, output int oe_n);
        logic [15:0] dummy;
        logic        t_o, t_m, e_o;
        run_frame(pre, op, phy, ra, wd, dummy, oe_n, t_o, t_m, e_o);
    endtask

    task automatic t_reset;
        chk("R1", "mdo_en", {31'b0, mdo_en}, 32'h0);
        chk("R1", "cfg0", cfg0, 32'h0);
        chk("R1", "cfg1", cfg1, 32'h0);
        chk("R1", "valids", {28'b0, cfg1_hi_vld, cfg1_lo_vld, cfg0_hi_vld, cfg0_lo_vld}, 32'h0);
    endtask

    task automatic t_coherence;
        logic [15:0] v;
        logic        ok;
        status1 = 32'hA5A5_1234;
        rd_reg(5'h15, 5'd3, v, ok);
        chk("R5", "high before any low read", {16'h0, v}, 32'h0);
        chk("R9", "read timing", {31'b0, ok}, 32'h1);
        rd_reg(5'h15, 5'd2, v, ok);
        chk("R5", "low half word1", {16'h0, v}, 32'h1234);
        status1 = 32'h5A5A_9999;
        rd_reg(5'h15, 5'd3, v, ok);
        chk("R5", "high keeps captured upper", {16'h0, v}, 32'hA5A5);
        chk("R9", "read timing", {31'b0, ok}, 32'h1);
        rd_reg(5'h15, 5'd2, v, ok);
        rd_reg(5'h15, 5'd3, v, ok);
        chk("R5", "high after new low read", {16'h0, v}, 32'h5A5A);
    endtask

    task automatic t_status;
        logic [15:0] v;
        logic        ok;
        logic [31:0] w [4];
        status0 = 32'h0123_4567;
        status1 = 32'h89AB_CDEF;
        status2 = 32'hFEDC_BA98;
        status3 = 32'h7654_3210;
        w[0] = status0; w[1] = status1; w[2] = status2; w[3] = status3;
        for (int k = 0; k < 4; k++) begin
            rd_reg(5'h15, 5'(2 * k), v, ok);
            chk("R4", "status low half", {16'h0, v}, {16'h0, w[k][15:0]});
            chk("R9", "low read timing", {31'b0, ok}, 32'h1);
            rd_reg(5'h15, 5'(2 * k + 1), v, ok);
            chk("R4", "status high half", {16'h0, v}, {16'h0, w[k][31:16]});
        end
    endtask

    task automatic t_cfg_write;
        int n;
        int c0, c1, c2, c3;
        c0 = vld_cnt[0]; c1 = vld_cnt[1]; c2 = vld_cnt[2]; c3 = vld_cnt[3];
        wr_reg(32, 2'b01, 5'h15, 5'd8, 16'hBEEF, n);
        chk("R6", "cfg0 after addr8", cfg0, 32'h0000_BEEF);
        chk("R7", "cfg0_lo_vld count", vld_cnt[0], c0 + 1);
        chk("R7", "value at cfg0_lo_vld", vld_val[0], 32'h0000_BEEF);
        chk("R7", "cfg0_hi_vld untouched", vld_cnt[1], c1);
        chk("R9", "no oe on write", n, 0);
        wr_reg(32, 2'b01, 5'h15, 5'd9, 16'hCAFE, n);
        chk("R6", "cfg0 after addr9", cfg0, 32'hCAFE_BEEF);
        chk("R7", "cfg0_hi_vld count", vld_cnt[1], c1 + 1);
        chk("R7", "value at cfg0_hi_vld", vld_val[1], 32'hCAFE_BEEF);
        wr_reg(32, 2'b01, 5'h15, 5'd11, 16'h1357, n);
        chk("R6", "cfg1 after addr11", cfg1, 32'h1357_0000);
        chk("R7", "cfg1_hi_vld count", vld_cnt[3], c3 + 1);
        wr_reg(32, 2'b01, 5'h15, 5'd10, 16'h2468, n);
        chk("R6", "cfg1 after addr10", cfg1, 32'h1357_2468);
        chk("R6", "cfg0 kept", cfg0, 32'hCAFE_BEEF);
        chk("R7", "cfg1_lo_vld count", vld_cnt[2], c2 + 1);
        chk("R7", "value at cfg1_lo_vld", vld_val[2], 32'h1357_2468);
        chk("R7", "pulse width one cycle", wide, 0);
    endtask

    task automatic t_readback;
        logic [15:0] v;
        logic        ok;
        rd_reg(5'h15, 5'd8, v, ok);
        chk("R8", "readback addr8", {16'h0, v}, 32'hBEEF);
        rd_reg(5'h15, 5'd9, v, ok);
        chk("R8", "readback addr9", {16'h0, v}, 32'hCAFE);
        rd_reg(5'h15, 5'd10, v, ok);
        chk("R8", "readback addr10", {16'h0, v}, 32'h2468);
        rd_reg(5'h15, 5'd11, v, ok);
        chk("R8", "readback addr11", {16'h0, v}, 32'h1357);
        rd_reg(5'h15, 5'd12, v, ok);
        chk("R8", "unmapped addr12", {16'h0, v}, 32'h0);
        chk("R9", "unmapped read timing", {31'b0, ok}, 32'h1);
        rd_reg(5'h15, 5'd31, v, ok);
        chk("R8", "unmapped addr31", {16'h0, v}, 32'h0);
    endtask

    task automatic t_wrong_port;
        int          n;
        int          c0;
        logic [15:0] v;
        logic        t_o, t_m, e_o;
        c0 = vld_cnt[0];
        wr_reg(32, 2'b01, 5'h14, 5'd8, 16'h0F0F, n);
        chk("R3", "cfg0 unchanged on foreign write", cfg0, 32'hCAFE_BEEF);
        chk("R3", "no strobe on foreign write", vld_cnt[0], c0);
        chk("R3", "no oe on foreign write", n, 0);
        run_frame(32, 2'b10, 5'h00, 5'd0, 16'h0, v, n, t_o, t_m, e_o);
        chk("R3", "no oe on foreign read", n, 0);
    endtask

    task automatic t_short_pre;
        int          n;
        int          c2;
        logic [15:0] v;
        logic        ok;
        c2 = vld_cnt[2];
        wr_reg(31, 2'b01, 5'h15, 5'd10, 16'h7777, n);
        chk("R2", "cfg1 unchanged after 31-bit preamble", cfg1, 32'h1357_2468);
        chk("R2", "no strobe after short preamble", vld_cnt[2], c2);
        rd_reg(5'h15, 5'd10, v, ok);
        chk("R2", "next full frame decoded", {16'h0, v}, 32'h2468);
        chk("R9", "read timing after recovery", {31'b0, ok}, 32'h1);
    endtask

    task automatic t_ignored;
        int          n;
        int          s;
        logic [15:0] v;
        logic        ok;
        s = vld_cnt[0] + vld_cnt[1] + vld_cnt[2] + vld_cnt[3];
        wr_reg(32, 2'b01, 5'h15, 5'd2, 16'h1111, n);
        rd_reg(5'h15, 5'd2, v, ok);
        chk("R10", "status read after write attempt", {16'h0, v}, {16'h0, status1[15:0]});
        wr_reg(32, 2'b01, 5'h15, 5'd15, 16'h2222, n);
        wr_reg(32, 2'b00, 5'h15, 5'd8, 16'h3333, n);
        chk("R10", "no oe for opcode 00", n, 0);
        wr_reg(32, 2'b11, 5'h15, 5'd9, 16'h4444, n);
        chk("R10", "no oe for opcode 11", n, 0);
        chk("R10", "cfg0 unchanged", cfg0, 32'hCAFE_BEEF);
        chk("R10", "cfg1 unchanged", cfg1, 32'h1357_2468);
        chk("R10", "no strobes", vld_cnt[0] + vld_cnt[1] + vld_cnt[2] + vld_cnt[3], s);
    endtask

    task automatic t_port_change;
        int n;
        int c2, c3;
        c2 = vld_cnt[2]; c3 = vld_cnt[3];
        port_addr = 5'h03;
        wr_reg(32, 2'b01, 5'h03, 5'd10, 16'hABCD, n);
        chk("R11", "write at new port", cfg1, 32'h1357_ABCD);
        chk("R11", "strobe at new port", vld_cnt[2], c2 + 1);
        wr_reg(32, 2'b01, 5'h15, 5'd11, 16'h5555, n);
        chk("R11", "old port now foreign", cfg1, 32'h1357_ABCD);
        chk("R11", "no strobe at old port", vld_cnt[3], c3);
        port_addr = 5'h15;
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            vld_cnt[k] = 0;
            vld_val[k] = '0;
        end
        rst_n     = 1'b0;
        mdc       = 1'b0;
        mdi       = 1'b1;
        port_addr = 5'h15;
        status0   = '0;
        status1   = '0;
        status2   = '0;
        status3   = '0;
        repeat (10) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        t_coherence();
        t_status();
        t_cfg_write();
        t_readback();
        t_wrong_port();
        t_short_pre();
        t_ignored();
        t_port_change();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule